// File: doc/BRIEF.md
# Filter Delay Preload and Output Scaling

This block sits beside a first-order digital filter section. It holds the two word-wide settings that shape the section's start-up and its output. The first is a signed 12-bit seed for the one-sample delay element (Z^-1). The second is an offset added to every filter result. The multiply-accumulate core, the coefficients and the bus decoder stay outside the block.

A write port accepts 16-bit word writes and ignores byte writes. On request, the delay element is loaded with the seed, sign-extended to the element's width. If the filter is busy computing with that element, the load is parked behind a pending flag and runs on the cycle the next computation starts.

Filter results arrive on a valid/ready stream. Each result has the offset added to it, is scaled by a selectable power of two, and is clipped to the signed 16-bit range. The output is one registered stage. A result is taken when `res_valid` and `res_ready` are both high. `res_ready` is high whenever the output stage is empty or the consumer accepts in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new result is taken.

Top module: `filt_delay_scale`

## Requirements
- R1: A write with `wr_word`=1 updates the register picked by `wr_sel` (0 = offset, 1 = seed). A write with `wr_word`=0 changes neither register.
- R2: An asynchronous reset (`rst_n` low) sets the seed register to 0xF000, `z_q` to 0, `pend_o` to 0 and `out_valid` to 0. After that, a preload gives `z_q` = 0.
- R3: An accepted result `r` gives `out_data` = clip((r + offset) * 2^shift). Both `r` and the offset are taken as signed 16-bit. The output appears on the cycle after acceptance.
- R4: `gain_sel` values 0 to 6 select a shift of 0 to 6. The value 7 acts as shift 6.
- R5: A scaled value above 32767 gives 0x7FFF. A scaled value below -32768 gives 0x8000.
- R6: A `ld_req` while `comp_busy`=0, or in a cycle with `comp_start`=1, loads `z_q` on the next edge. The loaded value is seed bits [11:0], sign-extended from bit 11.
- R7: A `ld_req` while `comp_busy`=1 and `comp_start`=0 sets `pend_o` and leaves `z_q` without a load. The parked load runs, and `pend_o` clears, on the next cycle with `comp_start`=1 or `comp_busy`=0.
- R8: With no load due, `z_upd_valid` copies `z_upd_data` into `z_q`. A load due in the same cycle wins over the update.
- R9: `res_ready` = !`out_valid` | `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold.
- R10: `stby`=1 resets the seed register to 0xF000 on the next edge, without touching the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby | input | 1 | Standby / module stop, re-initialises the seed register |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 1 | 1 = full word access; 0 = byte access (ignored) |
| wr_sel | input | 1 | 0 = offset register, 1 = seed register |
| wr_data | input | BW | Write data |
| ld_req | input | 1 | Preload request pulse from the filter control |
| comp_busy | input | 1 | Filter is computing with this delay element |
| comp_start | input | 1 | A computation begins this cycle |
| z_upd_valid | input | 1 | Delay element update from the MAC core |
| z_upd_data | input | DW | Delay element update value |
| z_q | output | DW | Delay element contents |
| pend_o | output | 1 | Deferred preload pending |
| gain_sel | input | 3 | Output shift select |
| res_valid | input | 1 | Filter result valid |
| res_ready | output | 1 | Result accepted when high with res_valid |
| res_data | input | BW | Filter result, signed |
| out_valid | output | 1 | Scaled output valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | BW | Offset, scaled and clipped output |

## Verification
The bench builds the block with a 20-bit delay element and keeps the 16-bit bus, the 12-bit seed and a maximum shift of 6. A delay element wider than the seed, but narrower than the default, still makes both sign-extension polarities visible on `z_q`. The full shift range lets an offset-adjusted result reach both clip rails, and it also exercises the out-of-range select value 7. A reference model runs alongside the design, and random traffic drives preload requests into busy windows, starts and delay updates in the same cycles.

// File: rtl/fds_pkg.sv
package fds_pkg;
  typedef enum logic {
    SEL_OFFSET = 1'b0,
    SEL_SEED   = 1'b1
  } fds_sel_e;

  typedef struct packed {
    logic     en;
    logic     word;
    fds_sel_e sel;
  } fds_wctl_s;
endpackage

// File: rtl/fds_regs.sv
module fds_regs
  import fds_pkg::*;
#(
  parameter int BW = 16,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby,
  input  fds_wctl_s     wctl,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] off_q,
  output logic [BW-1:0] seed_q
);
  localparam logic [BW-1:0] SEED_RST = {{(BW-IW){1'b1}}, {IW{1'b0}}};

  logic wr_ok;
  assign wr_ok = wctl.en && wctl.word;

  // offset has no reset: contents undefined until written
  always_ff @(posedge clk) begin
    if (wr_ok && wctl.sel == SEL_OFFSET) off_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               seed_q <= SEED_RST;
    else if (stby)                            seed_q <= SEED_RST;
    else if (wr_ok && wctl.sel == SEL_SEED)   seed_q <= wr_data;
  end

  AST_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl.en && !wctl.word && !stby) |=> $stable(seed_q)); // R1
  AST_STBY_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (seed_q == SEED_RST)); // R10
endmodule

// File: rtl/fds_zload.sv
module fds_zload #(
  parameter int DW = 24,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic          comp_busy,
  input  logic          comp_start,
  input  logic          z_upd_valid,
  input  logic [DW-1:0] z_upd_data,
  input  logic [IW-1:0] seed,
  output logic [DW-1:0] z_q,
  output logic          pend_q
);
  logic [DW-1:0] ld_val;
  logic          ld_window;
  logic          ld_now;

  generate
    if (DW > IW) begin : g_sext
      assign ld_val = {{(DW-IW){seed[IW-1]}}, seed};
    end else begin : g_trunc
      assign ld_val = seed[DW-1:0];
    end
  endgenerate

  // a load may run when the element is free or a computation is just starting
  assign ld_window = !comp_busy || comp_start;
  assign ld_now    = (ld_req || pend_q) && ld_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q    <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ld_now)           z_q <= ld_val;
      else if (z_upd_valid) z_q <= z_upd_data;
      if (ld_now)           pend_q <= 1'b0;
      else if (ld_req)      pend_q <= 1'b1;
    end
  end

  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !comp_busy) |=> (z_q == $past(ld_val))); // R6
  AST_DEFER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && comp_busy && !comp_start) |=> pend_q); // R7
  AST_DEFER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && comp_start) |=> (!pend_q && z_q == $past(ld_val))); // R7
  AST_UPD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (z_upd_valid && !ld_req && !pend_q) |=> (z_q == $past(z_upd_data))); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (z_upd_valid && pend_q && comp_start) |=> (z_q == $past(ld_val))); // R8
endmodule

// File: rtl/fds_scale.sv
module fds_scale #(
  parameter int BW        = 16,
  parameter int MAX_SHIFT = 6,
  localparam int GSW      = $clog2(MAX_SHIFT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BW-1:0]  off,
  input  logic [GSW-1:0] gain_sel,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic [BW-1:0]  res_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [BW-1:0]  out_data
);
  localparam int SW = BW + 1;
  localparam int WW = SW + MAX_SHIFT;
  localparam logic [BW-1:0] POS_RAIL = {1'b0, {(BW-1){1'b1}}};
  localparam logic [BW-1:0] NEG_RAIL = {1'b1, {(BW-1){1'b0}}};

  logic [SW-1:0]  sum;
  logic [GSW-1:0] shamt;
  logic [WW-1:0]  wide;
  logic [BW-1:0]  clipped;
  logic           fits;
  logic           take;

  assign sum   = {res_data[BW-1], res_data} + {off[BW-1], off};
  assign shamt = (gain_sel > GSW'(MAX_SHIFT)) ? GSW'(MAX_SHIFT) : gain_sel;
  assign wide  = {{MAX_SHIFT{sum[SW-1]}}, sum} << shamt;

  // value fits when every bit above the result's sign bit copies the sign
  assign fits  = (wide[WW-1:BW-1] == {(WW-BW+1){1'b0}}) ||
                 (wide[WW-1:BW-1] == {(WW-BW+1){1'b1}});

  always_comb begin
    if (fits)             clipped = wide[BW-1:0];
    else if (wide[WW-1])  clipped = NEG_RAIL;
    else                  clipped = POS_RAIL;
  end

  assign res_ready = !out_valid || out_ready;
  assign take      = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (res_ready) begin
      out_valid <= res_valid;
      if (take) out_data <= clipped;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> out_valid); // R9
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !res_ready); // R9
endmodule

// File: rtl/filt_delay_scale.sv
module filt_delay_scale
  import fds_pkg::*;
#(
  parameter int DW        = 24,
  parameter int IW        = 12,
  parameter int BW        = 16,
  parameter int MAX_SHIFT = 6,
  localparam int GSW      = $clog2(MAX_SHIFT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stby,
  input  logic           wr_en,
  input  logic           wr_word,
  input  logic           wr_sel,
  input  logic [BW-1:0]  wr_data,
  input  logic           ld_req,
  input  logic           comp_busy,
  input  logic           comp_start,
  input  logic           z_upd_valid,
  input  logic [DW-1:0]  z_upd_data,
  output logic [DW-1:0]  z_q,
  output logic           pend_o,
  input  logic [GSW-1:0] gain_sel,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic [BW-1:0]  res_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [BW-1:0]  out_data
);
  fds_wctl_s     wctl;
  logic [BW-1:0] off_q;
  logic [BW-1:0] seed_q;

  assign wctl.en   = wr_en;
  assign wctl.word = wr_word;
  assign wctl.sel  = fds_sel_e'(wr_sel);

  fds_regs #(.BW(BW), .IW(IW)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .stby    (stby),
    .wctl    (wctl),
    .wr_data (wr_data),
    .off_q   (off_q),
    .seed_q  (seed_q)
  );

  fds_zload #(.DW(DW), .IW(IW)) i_zload (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_req      (ld_req),
    .comp_busy   (comp_busy),
    .comp_start  (comp_start),
    .z_upd_valid (z_upd_valid),
    .z_upd_data  (z_upd_data),
    .seed        (seed_q[IW-1:0]),
    .z_q         (z_q),
    .pend_q      (pend_o)
  );

  fds_scale #(.BW(BW), .MAX_SHIFT(MAX_SHIFT)) i_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .off       (off_q),
    .gain_sel  (gain_sel),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: tb/test_filt_delay_scale.sv
`timescale 1ns/1ps
module test_filt_delay_scale;
  localparam int DW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 0, wr_en = 0, wr_word = 0, wr_sel = 0;
  logic [15:0] wr_data = '0;
  logic ld_req = 0, comp_busy = 0, comp_start = 0, z_upd_valid = 0;
  logic [DW-1:0] z_upd_data = '0;
  logic [DW-1:0] z_q;
  logic pend_o;
  logic [2:0] gain_sel = '0;
  logic res_valid = 0, res_ready, out_valid, out_ready = 1;
  logic [15:0] res_data = '0, out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  filt_delay_scale #(.DW(DW)) i_filt_delay_scale (
    .clk(clk), .rst_n(rst_n), .stby(stby), .wr_en(wr_en), .wr_word(wr_word),
    .wr_sel(wr_sel), .wr_data(wr_data), .ld_req(ld_req), .comp_busy(comp_busy),
    .comp_start(comp_start), .z_upd_valid(z_upd_valid), .z_upd_data(z_upd_data),
    .z_q(z_q), .pend_o(pend_o), .gain_sel(gain_sel), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0]   m_seed = 16'hF000, m_off = '0, m_od = '0;
  logic [DW-1:0] m_z = '0;
  bit            m_pend = 0, m_ov = 0;

  function automatic logic [15:0] m_scale(logic [15:0] r, logic [15:0] o, logic [2:0] g);
    int s, sh, v;
    s  = int'($signed(r)) + int'($signed(o));
    sh = (g > 3'd6) ? 6 : int'(g);
    v  = s * (1 << sh);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  always @(posedge clk) begin
    bit due;
    if (!rst_n) begin
      m_seed = 16'hF000; m_z = '0; m_pend = 0; m_ov = 0;
    end else begin
      due = (ld_req || m_pend) && (!comp_busy || comp_start);
      if (due) begin
        m_z = {{(DW-12){m_seed[11]}}, m_seed[11:0]};
        m_pend = 0;
      end else begin
        if (ld_req) m_pend = 1;
        if (z_upd_valid) m_z = z_upd_data;
      end
      if (!m_ov || out_ready) begin
        if (res_valid) m_od = m_scale(res_data, m_off, gain_sel);
        m_ov = res_valid;
      end
      if (stby) m_seed = 16'hF000;
      else if (wr_en && wr_word && wr_sel) m_seed = wr_data;
      if (wr_en && wr_word && !wr_sel) m_off = wr_data;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 R7 R8 z_q", 32'(z_q), 32'(m_z));
      chk("R7 pend_o", 32'(pend_o), 32'(m_pend));
      chk("R9 out_valid", 32'(out_valid), 32'(m_ov));
      chk("R9 res_ready", 32'(res_ready), 32'(!m_ov || out_ready));
      if (m_ov) chk("R3 R4 R5 out_data", 32'(out_data), 32'(m_od));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(bit sel, logic [15:0] d, bit word);
    wr_en = 1; wr_sel = sel; wr_data = d; wr_word = word;
    tick();
    wr_en = 0; wr_word = 0;
  endtask

  task automatic pulse_ld();
    ld_req = 1; tick(); ld_req = 0;
  endtask

  task automatic send(logic [15:0] r, logic [2:0] g);
    res_valid = 1; res_data = r; gain_sel = g; out_ready = 1;
    tick();
    res_valid = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R2 reset z_q", 32'(z_q), 0);
    chk("R2 reset pend_o", 32'(pend_o), 0);
    chk("R2 reset out_valid", 32'(out_valid), 0);
    rst_n = 1; tick();

    // R2: seed reset value 0xF000 -> loads zero
    z_upd_valid = 1; z_upd_data = 20'h00055; tick(); z_upd_valid = 0;
    chk("R8 update copy", 32'(z_q), 32'h00055);
    pulse_ld();
    chk("R2 seed reset load", 32'(z_q), 0);

    // R1/R6: word write then negative seed sign extension
    wr(1'b1, 16'h0ABC, 1'b1);
    pulse_ld();
    chk("R6 negative sext", 32'(z_q), 32'hFFABC);
    // R1: byte write ignored
    z_upd_valid = 1; z_upd_data = 20'h00001; tick(); z_upd_valid = 0;
    wr(1'b1, 16'h0123, 1'b0);
    pulse_ld();
    chk("R1 byte write ignored", 32'(z_q), 32'hFFABC);

    // R7: deferred load
    wr(1'b1, 16'h0345, 1'b1);
    comp_busy = 1; pulse_ld();
    chk("R7 pending set", 32'(pend_o), 1);
    chk("R7 no load while busy", 32'(z_q), 32'hFFABC);
    z_upd_valid = 1; z_upd_data = 20'h0AAAA; tick();
    chk("R8 update while pending", 32'(z_q), 32'h0AAAA);
    comp_start = 1; z_upd_data = 20'h0BBBB; tick();
    comp_start = 0; z_upd_valid = 0; comp_busy = 0;
    chk("R7 deferred load runs", 32'(z_q), 32'h00345);
    chk("R7 pending cleared", 32'(pend_o), 0);
    chk("R8 load beats update", 32'(z_q), 32'h00345);

    // R10: standby re-initialises seed
    stby = 1; tick(); stby = 0;
    pulse_ld();
    chk("R10 standby seed", 32'(z_q), 0);

    // output path
    wr(1'b0, 16'h0010, 1'b1);
    send(16'h0100, 3'd0); chk("R3 offset add", 32'(out_data), 32'h0110);
    send(16'h0100, 3'd4); chk("R4 shift 4", 32'(out_data), 32'h1100);
    send(16'h0100, 3'd7); chk("R4 select 7 as 6", 32'(out_data), 32'h4400);
    send(16'h7000, 3'd1); chk("R5 positive rail", 32'(out_data), 32'h7FFF);
    send(16'h8000, 3'd2); chk("R5 negative rail", 32'(out_data), 32'h8000);
    // R9: stall holds output
    out_ready = 0; res_valid = 1; res_data = 16'h0001; gain_sel = 0; tick();
    chk("R9 stall not ready", 32'(res_ready), 0);
    chk("R9 stall data held", 32'(out_data), 32'h8000);
    tick();
    chk("R9 stall still held", 32'(out_data), 32'h8000);
    out_ready = 1; tick(); res_valid = 0;
    chk("R9 stalled word replaced", 32'(out_data), 32'h0011);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      wr_en       = ($urandom % 6) == 0;
      wr_word     = ($urandom % 4) != 0;
      wr_sel      = 1'($urandom);
      wr_data     = 16'($urandom);
      stby        = ($urandom % 40) == 0;
      ld_req      = ($urandom % 6) == 0;
      comp_busy   = ($urandom % 2) == 0;
      comp_start  = ($urandom % 8) == 0;
      z_upd_valid = ($urandom % 3) == 0;
      z_upd_data  = DW'($urandom);
      res_valid   = 1'($urandom);
      res_data    = 16'($urandom);
      gain_sel    = 3'($urandom);
      out_ready   = ($urandom % 4) != 0;
      tick();
    end
    wr_en = 0; ld_req = 0; stby = 0; res_valid = 0; z_upd_valid = 0;
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule